// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management master for a clause-22 style two-wire management bus. A host raises a one-cycle start strobe with a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The master then produces the management clock and shifts one complete register access frame on the data line. The data line is modelled as three separate signals: output value, output enable and input. The PHY address, register address, write data and direction are latched on the accepted start, so the host may change them once the frame is running.

The management clock comes from a divider counted in system clocks. `HALF_CYC` sets the low phase. The high phase lasts `max(HALF_CYC, SAMPLE_CYC)`, so the PHY has at least the required access time before the master samples. Elaboration checks compare these counts, together with the input synchroniser depth, against the 400 ns period, the 200 ns low phase and the 300 ns read-access limits. The outgoing data changes one system clock after each falling edge and stays stable for the whole high phase.

A read whose turnaround bit comes back high counts as a missing PHY. The master keeps clocking with the line released for a fixed number of extra cycles so the PHY drains any bits it is still shifting. It then finishes with the error flag set and zero read data. Every successful frame ends with one extra clock cycle with the line released.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc_o, mdio_oe_o, busy_o, done_o and err_o are 0 and rdata_o is 0.
- R2: Each frame starts with 32 driven '1' bits followed by the driven start pattern 0 then 1; a bit is the mdio_o value seen at an mdc_o rising edge with mdio_oe_o high.
- R3: The two driven bits after the start pattern are 1,0 for a read (rd_i=1) and 0,1 for a write (rd_i=0).
- R4: The 5 PHY address bits and then the 5 register address bits follow, most significant bit first, taken from the values latched at start.
- R5: A write then drives 1,0 and the 16 data bits MSB first, then gives one rising edge with mdio_oe_o low: 65 rising edges in all. rdata_o is left unchanged.
- R6: A read releases the line (mdio_oe_o low) from rising edge 47 onward. If the sampled turnaround bit is 0, 16 bits are shifted in MSB first and one released tail edge follows: 64 rising edges in all. rdata_o then holds the 16 bits and err_o is 0.
- R7: If the read turnaround bit is 1, the master gives 32 more released rising edges (79 in all) and finishes with err_o=1 and rdata_o=0.
- R8: mdc_o stays low for HALF_CYC clocks and high for max(HALF_CYC, SAMPLE_CYC) clocks. mdio_o and mdio_oe_o do not change while mdc_o is high. Read bits are taken at the end of the high phase, so data that the PHY settles 8 clocks after the rising edge is captured correctly.
- R9: busy_o rises on an accepted start and stays high until done_o. done_o is a one-cycle pulse, seen N*SLOT+1 clock edges after the start edge is counted, where N is the frame's rising-edge count and SLOT is the mdc period in clocks.
- R10: A start strobe while busy_o is high is ignored and the running frame's bits, length and result do not change.
- R11: mdc_o is low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to start a frame |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write frame |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read turnaround was not driven low; valid from done until the next start |
| rdata_o | output | 16 | Data of the last read frame |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Each frame result is due a fixed number of clock edges after the start edge: the rising-edge count of the frame times the 31-clock slot, plus one. The bench counts edges from the start strobe and checks that done_o appears exactly there, with busy_o high on every sampled cycle before it. The serial bits and the output enable are captured at each mdc_o rising edge by a PHY model in the bench that samples on the falling system-clock edge. That model drives wrong data for the first 8 clocks of every high phase, so capture at the end of the high phase is tested. Pulse width and idle level are checked on the falling edges that follow done_o.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_CMD   = 3'd1,
      PH_TA    = 3'd2,
      PH_RDAT  = 3'd3,
      PH_FLUSH = 3'd4,
      PH_TAIL  = 3'd5
   } mdio_phase_e;

   localparam logic [1:0] SOF_PAT = 2'b01;
   localparam logic [1:0] OPC_RD  = 2'b10;
   localparam logic [1:0] OPC_WR  = 2'b01;
   localparam logic [1:0] TA_WR   = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int LOW_CYC  = 13,
   parameter int HIGH_CYC = 18
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic mdc_o,
   output logic slot_head_o,
   output logic slot_tail_o
);
   localparam int SLOT = LOW_CYC + HIGH_CYC;
   localparam int CW   = $clog2(SLOT);

   logic [CW-1:0] cnt_q;
   logic          mdc_q;
   logic          at_end;

   assign at_end      = run_i && (cnt_q == CW'(SLOT - 1));
   assign slot_head_o = run_i && (cnt_q == '0);
   assign slot_tail_o = at_end;
   assign mdc_o       = mdc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else begin
         if (!run_i || at_end) cnt_q <= '0;
         else                  cnt_q <= cnt_q + 1'b1;
         if (!run_i || at_end)                  mdc_q <= 1'b0;
         else if (cnt_q == CW'(LOW_CYC - 1))    mdc_q <= 1'b1;
      end
   end

   // R11: once the run request drops the clock is low on the next cycle
   assert_mdc_stops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !mdc_o);

   // R8: a slot always ends with the clock high
   assert_tail_in_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_tail_o |-> mdc_o);

endmodule

// File: rtl/mdio_tx_path.sv
module mdio_tx_path #(
   parameter int W = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_vec_i,
   input  logic         shift_i,
   input  logic         head_i,
   input  logic         drive_i,
   output logic         mdio_o,
   output logic         mdio_oe_o
);
   logic [W-1:0] sh_q;
   logic         out_q;
   logic         oe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         out_q <= 1'b1;
         oe_q  <= 1'b0;
      end else begin
         if (load_i)       sh_q <= load_vec_i;
         else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
         if (head_i) begin
            out_q <= drive_i ? sh_q[W-1] : 1'b1;
            oe_q  <= drive_i;
         end
      end
   end

   assign mdio_o    = out_q;
   assign mdio_oe_o = oe_q;

endmodule

// File: rtl/mdio_rx_path.sv
module mdio_rx_path #(
   parameter int DW   = 16,
   parameter int SYNC = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          mdio_i,
   input  logic          take_i,
   input  logic          fin_rd_ok_i,
   input  logic          fin_bad_i,
   output logic          bit_o,
   output logic [DW-1:0] rdata_o
);
   logic          s_bit;
   logic [DW-1:0] sh_q;
   logic [DW-1:0] rd_q;

   generate
      if (SYNC == 0) begin : g_nosync
         assign s_bit = mdio_i;
      end else begin : g_sync
         logic [SYNC-1:0] ff_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q <= '1;
            else begin
               ff_q[0] <= mdio_i;
               for (int i = 1; i < SYNC; i++) ff_q[i] <= ff_q[i-1];
            end
         end
         assign s_bit = ff_q[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q <= '0;
         rd_q <= '0;
      end else begin
         if (take_i)           sh_q <= {sh_q[DW-2:0], s_bit};
         if (fin_bad_i)        rd_q <= '0;
         else if (fin_rd_ok_i) rd_q <= sh_q;
      end
   end

   assign bit_o   = s_bit;
   assign rdata_o = rd_q;

   // R7: a failed read never leaves data behind
   assert_bad_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_bad_i |=> (rdata_o == '0));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int HDR_BITS   = 46,
   parameter int WR_BITS    = 64,
   parameter int DW         = 16,
   parameter int FLUSH_BITS = 32
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        start_i,
   input  logic        rd_i,
   input  logic        slot_tail_i,
   input  logic        ta_bit_i,
   output logic        load_o,
   output logic        shift_o,
   output logic        take_o,
   output logic        drive_o,
   output logic        fin_rd_ok_o,
   output logic        fin_bad_o,
   output logic        busy_o,
   output logic        done_o,
   output logic        err_o
);
   localparam int MAXC = (WR_BITS > FLUSH_BITS) ? WR_BITS : FLUSH_BITS;
   localparam int CW   = $clog2(MAXC + 1);

   mdio_phase_e   ph_q;
   logic [CW-1:0] left_q;
   logic          rd_q;
   logic          done_q;
   logic          err_q;
   logic          last_bit;

   assign last_bit    = slot_tail_i && (left_q == '0);
   assign busy_o      = (ph_q != PH_IDLE);
   assign load_o      = start_i && (ph_q == PH_IDLE);
   assign shift_o     = slot_tail_i && (ph_q == PH_CMD);
   assign take_o      = slot_tail_i && (ph_q == PH_RDAT);
   assign drive_o     = (ph_q == PH_CMD);
   assign fin_rd_ok_o = last_bit && (ph_q == PH_TAIL) && rd_q;
   assign fin_bad_o   = last_bit && (ph_q == PH_FLUSH);
   assign done_o      = done_q;
   assign err_o       = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         left_q <= '0;
         rd_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (ph_q == PH_IDLE) begin
            if (start_i) begin
               ph_q   <= PH_CMD;
               rd_q   <= rd_i;
               left_q <= rd_i ? CW'(HDR_BITS - 1) : CW'(WR_BITS - 1);
               err_q  <= 1'b0;
            end
         end else if (slot_tail_i) begin
            if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end else begin
               unique case (ph_q)
                  PH_CMD:   ph_q <= rd_q ? PH_TA : PH_TAIL;
                  PH_TA: begin
                     if (ta_bit_i) begin
                        ph_q   <= PH_FLUSH;
                        left_q <= CW'(FLUSH_BITS - 1);
                     end else begin
                        ph_q   <= PH_RDAT;
                        left_q <= CW'(DW - 1);
                     end
                  end
                  PH_RDAT:  ph_q <= PH_TAIL;
                  PH_FLUSH: begin
                     ph_q   <= PH_IDLE;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end
                  PH_TAIL: begin
                     ph_q   <= PH_IDLE;
                     done_q <= 1'b1;
                  end
                  default:  ph_q <= PH_IDLE;
               endcase
            end
         end
      end
   end

   // R9: completion is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R9: busy only falls together with the done pulse
   assert_busy_until_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);

   // R7: the error flag only appears with completion
   assert_err_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> done_o);

   // R10: a start during a frame does not change the latched direction
   assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> (busy_o && $stable(rd_q)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 20000,
   parameter int HALF_CYC      = 13,
   parameter int SAMPLE_CYC    = 18,
   parameter int PRE_BITS      = 32,
   parameter int ADDR_W        = 5,
   parameter int DATA_W        = 16,
   parameter int FLUSH_BITS    = 32,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);
   localparam int HIGH_CYC = (SAMPLE_CYC > HALF_CYC) ? SAMPLE_CYC : HALF_CYC;
   localparam int HDR_BITS = PRE_BITS + 4 + 2 * ADDR_W;
   localparam int WR_BITS  = HDR_BITS + 2 + DATA_W;
   localparam int PAD_BITS = WR_BITS - HDR_BITS;

   generate
      if (HALF_CYC < 2) begin : g_chk_half
         $error("HALF_CYC must leave at least one clock of data setup");
      end
      if (HALF_CYC * CLK_PERIOD_PS < 200000) begin : g_chk_low
         $error("mdc low phase shorter than 200 ns");
      end
      if ((HALF_CYC + HIGH_CYC) * CLK_PERIOD_PS < 400000) begin : g_chk_period
         $error("mdc period shorter than 400 ns");
      end
      if ((HIGH_CYC - SYNC_STAGES) * CLK_PERIOD_PS < 300000) begin : g_chk_access
         $error("read sample earlier than 300 ns after the rising edge");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_chk_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
      if (ADDR_W < 1 || DATA_W < 2 || PRE_BITS < 1 || FLUSH_BITS < 1) begin : g_chk_w
         $error("field widths out of range");
      end
   endgenerate

   logic                run;
   logic                head, tail;
   logic                load, shift, take, drive;
   logic                fin_rd_ok, fin_bad;
   logic                ta_bit;
   logic [HDR_BITS-1:0] hdr;
   logic [WR_BITS-1:0]  load_vec;

   always_comb begin
      hdr      = {{PRE_BITS{1'b1}}, SOF_PAT, (rd_i ? OPC_RD : OPC_WR), phy_addr_i, reg_addr_i};
      load_vec = rd_i ? {hdr, {PAD_BITS{1'b0}}} : {hdr, TA_WR, wdata_i};
   end

   mdio_frame_seq #(
      .HDR_BITS   (HDR_BITS),
      .WR_BITS    (WR_BITS),
      .DW         (DATA_W),
      .FLUSH_BITS (FLUSH_BITS)
   ) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .rd_i        (rd_i),
      .slot_tail_i (tail),
      .ta_bit_i    (ta_bit),
      .load_o      (load),
      .shift_o     (shift),
      .take_o      (take),
      .drive_o     (drive),
      .fin_rd_ok_o (fin_rd_ok),
      .fin_bad_o   (fin_bad),
      .busy_o      (run),
      .done_o      (done_o),
      .err_o       (err_o)
   );

   mdio_mdc_gen #(
      .LOW_CYC  (HALF_CYC),
      .HIGH_CYC (HIGH_CYC)
   ) u_mdc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .mdc_o       (mdc_o),
      .slot_head_o (head),
      .slot_tail_o (tail)
   );

   mdio_tx_path #(
      .W (WR_BITS)
   ) u_tx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_vec_i (load_vec),
      .shift_i    (shift),
      .head_i     (head),
      .drive_i    (drive),
      .mdio_o     (mdio_o),
      .mdio_oe_o  (mdio_oe_o)
   );

   mdio_rx_path #(
      .DW   (DATA_W),
      .SYNC (SYNC_STAGES)
   ) u_rx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mdio_i      (mdio_i),
      .take_i      (take),
      .fin_rd_ok_i (fin_rd_ok),
      .fin_bad_i   (fin_bad),
      .bit_o       (ta_bit),
      .rdata_o     (rdata_o)
   );

   assign busy_o = run;

   // R8: the line is held for the whole high phase of the clock
   assert_hold_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

   // R11: no clock activity between frames
   assert_mdc_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !mdc_o);

   // R9: done is only reported once the frame has stopped
   assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   localparam int HALF = 13;
   localparam int SAMP = 18;
   localparam int HIGH = 18;
   localparam int SLOT = HALF + HIGH;
   localparam int HDR  = 46;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd = 1'b0;
   logic [4:0]  pa = '0;
   logic [4:0]  ra = '0;
   logic [15:0] wd = '0;
   logic        busy, done, err, mdc, mdo, oe;
   logic [15:0] rdata;
   logic        mdi = 1'b1;

   always #10 clk = ~clk;

   mdio_master #(.HALF_CYC(HALF), .SAMPLE_CYC(SAMP)) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
      .phy_addr_i(pa), .reg_addr_i(ra), .wdata_i(wd),
      .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
      .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdi)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural PHY and bus monitor
   int          nrise = 0;
   bit          rec_oe [0:127];
   bit          rec_d  [0:127];
   bit          exp_oe [0:127];
   bit          exp_d  [0:127];
   bit          prev_mdc = 1'b0;
   int          hi_run = 0, lo_run = 0, bad_hi = 0, bad_lo = 0;
   bit          phy_rd = 1'b0, phy_ta_bad = 1'b0;
   logic [15:0] phy_val = '0;
   int          lag = 0;
   bit          lag_val = 1'b1;

   always @(negedge clk) begin
      if (mdc) hi_run++;
      if (!mdc && prev_mdc) begin
         if (hi_run != HIGH) bad_hi++;
         hi_run = 0;
      end
      if (mdc && !prev_mdc) begin
         automatic int k = nrise;
         automatic bit tgt = 1'b1;
         if (k < 128) begin
            rec_oe[k] = oe;
            rec_d[k]  = mdo;
         end
         if (lo_run != HALF) bad_lo++;
         lo_run = 0;
         if (phy_rd) begin
            if (k == HDR) tgt = phy_ta_bad;
            else if (!phy_ta_bad && k > HDR && k <= HDR + 16) tgt = phy_val[HDR + 16 - k];
            else if (phy_ta_bad && k > HDR) tgt = (k % 2 == 1);
         end
         mdi     = ~tgt;
         lag     = 8;
         lag_val = tgt;
         nrise++;
      end else if (lag > 0) begin
         lag--;
         if (lag == 0) mdi = lag_val;
      end
      if (!mdc && busy) lo_run++;
      if (!busy) lo_run = 0;
      prev_mdc = mdc;
   end

   int cyc = 0;
   always @(posedge clk) cyc++;

   task automatic build_exp(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] w, bit bad,
                            output int n);
      for (int i = 0; i < 128; i++) begin exp_oe[i] = 1'b0; exp_d[i] = 1'b1; end
      for (int i = 0; i < 32; i++) begin exp_oe[i] = 1'b1; exp_d[i] = 1'b1; end
      exp_oe[32] = 1; exp_d[32] = 0; exp_oe[33] = 1; exp_d[33] = 1;
      exp_oe[34] = 1; exp_d[34] = r; exp_oe[35] = 1; exp_d[35] = ~r;
      for (int i = 0; i < 5; i++) begin
         exp_oe[36+i] = 1; exp_d[36+i] = p[4-i];
         exp_oe[41+i] = 1; exp_d[41+i] = g[4-i];
      end
      if (!r) begin
         exp_oe[46] = 1; exp_d[46] = 1; exp_oe[47] = 1; exp_d[47] = 0;
         for (int j = 0; j < 16; j++) begin exp_oe[48+j] = 1; exp_d[48+j] = w[15-j]; end
         n = 65;
      end else begin
         n = bad ? 79 : 64;
      end
   endtask

   task automatic cmp_range(int lo, int hi, string req, string what);
      automatic int bad = 0;
      for (int i = lo; i <= hi; i++) begin
         if (rec_oe[i] != exp_oe[i]) bad++;
         else if (exp_oe[i] && rec_d[i] != exp_d[i]) bad++;
      end
      chk(bad == 0, req, what, bad, 0);
   endtask

   logic [15:0] last_rd = '0;

   task automatic run_frame(bit r, logic [4:0] p, logic [4:0] g, logic [15:0] w,
                            bit bad, logic [15:0] pv, bit poke);
      automatic int n;
      automatic int edges;
      automatic int busy_gaps = 0;
      build_exp(r, p, g, w, bad, n);
      @(negedge clk);
      phy_rd = r; phy_ta_bad = bad; phy_val = pv;
      nrise = 0; bad_hi = 0; bad_lo = 0;
      rd = r; pa = p; ra = g; wd = w; start = 1'b1;
      @(posedge clk);
      edges = 1;
      @(negedge clk);
      start = 1'b0;
      // change inputs after acceptance: frame must use latched values (R4)
      rd = ~r; pa = ~p; ra = ~g; wd = ~w;
      while (!done && edges < 4000) begin
         if (!busy) busy_gaps++;
         @(posedge clk);
         edges++;
         @(negedge clk);
         start = poke && (edges == 300 || edges == 301);
      end
      start = 1'b0;
      chk(edges == n * SLOT + 1, "R9", "done latency in edges", edges, n * SLOT + 1);
      chk(busy_gaps == 0 && !busy, "R9", "busy high until done", busy_gaps, 0);
      chk(nrise == n, r ? (bad ? "R7" : "R6") : "R5", "rising edge count", nrise, n);
      if (poke) chk(nrise == n, "R10", "mid-frame start ignored", nrise, n);
      chk(bad_hi == 0 && bad_lo == 0, "R8", "mdc phase lengths", bad_hi + bad_lo, 0);
      cmp_range(0, 33, "R2", "preamble and start");
      cmp_range(34, 35, "R3", "opcode");
      cmp_range(36, 45, "R4", "addresses");
      if (!r) begin
         cmp_range(46, 64, "R5", "turnaround, data, tail");
         chk(err == 0, "R5", "err after write", err, 0);
         chk(rdata == last_rd, "R5", "rdata unchanged by write", rdata, last_rd);
      end else if (!bad) begin
         cmp_range(46, 63, "R6", "released after address");
         chk(err == 0, "R6", "err after good read", err, 0);
         chk(rdata == pv, "R6", "read data", rdata, pv);
         if (poke) chk(rdata == pv, "R10", "read data with mid-frame start", rdata, pv);
         last_rd = pv;
      end else begin
         cmp_range(46, 78, "R7", "released during flush");
         chk(err == 1, "R7", "err flag", err, 1);
         chk(rdata == 0, "R7", "rdata cleared", rdata, 0);
         last_rd = '0;
      end
      @(negedge clk);
      chk(done == 0, "R9", "done one cycle wide", done, 0);
      repeat (40) begin
         @(negedge clk);
         if (mdc || busy) break;
      end
      chk(!mdc && !busy && nrise == n, "R11", "mdc idle low after frame", {mdc, busy}, 0);
   endtask

   initial begin
      automatic int unsigned seed = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      chk(!mdc && !oe && !busy && !done && !err && rdata == 0, "R1", "outputs in reset",
          {mdc, oe, busy, done, err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!mdc && !oe && !busy && !done && !err && rdata == 0, "R1", "outputs after reset",
          {mdc, oe, busy, done, err}, 0);
      // directed corners
      run_frame(1'b0, 5'h1F, 5'h00, 16'hA55A, 1'b0, 16'h0000, 1'b0);
      run_frame(1'b1, 5'h00, 5'h1F, 16'h0000, 1'b0, 16'h8001, 1'b0);
      run_frame(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b1, 16'hFFFF, 1'b0);
      run_frame(1'b0, 5'h0A, 5'h15, 16'hFFFF, 1'b0, 16'h0000, 1'b0);
      run_frame(1'b0, 5'h03, 5'h11, 16'h1234, 1'b0, 16'h0000, 1'b1);
      run_frame(1'b1, 5'h07, 5'h02, 16'h0000, 1'b0, 16'h5AA5, 1'b1);
      run_frame(1'b1, 5'h1C, 5'h04, 16'h0000, 1'b0, 16'h0000, 1'b0);
      // constrained random
      for (int t = 0; t < 12; t++) begin
         automatic bit          r  = $urandom % 2;
         automatic bit          bd = r && ($urandom % 4 == 0);
         automatic logic [4:0]  p  = 5'($urandom);
         automatic logic [4:0]  g  = 5'($urandom);
         automatic logic [15:0] w  = 16'($urandom);
         automatic logic [15:0] v  = 16'($urandom);
         run_frame(r, p, g, w, bd, v, ($urandom % 5 == 0));
      end
      if (seed == 0) $display("seed zero");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      wait (cyc > 190000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule